// File: doc/BRIEF.md
# NaN-Boxing Floating-Point Register File

This block holds the floating-point architectural registers of a core that runs both single and double precision arithmetic. There are 32 entries, each 64 bits wide. The block has one write port and two independent read ports. Each port carries a format bit that selects a 32-bit (single) or 64-bit (double) access.

A single-precision value is kept in the low half of its entry. On every narrow write the block forces the high half to all ones. The stored word therefore reads as a negative quiet NaN when it is viewed as a double. A narrow read comes in one of two kinds, selected per port:
- A **transfer** read serves stores and float-to-integer moves. It returns the low half as stored and never looks at the high half.
- A **compute** read serves arithmetic operands. It checks the boxing first. If any high bit is zero, it delivers the single-precision canonical NaN in place of the stored value and raises a per-port substitution flag.

Writes commit on the rising clock edge. Reads are combinational. A read never sees a write that is being presented in the same cycle.

Top module: `fprf_nanbox`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every entry is cleared to zero. After reset, a 64-bit read of any entry returns 0.
- R2: A narrow write (`wr_fmt`=0) stores `{32'hFFFF_FFFF, wr_data[31:0]}`. `wr_data[63:32]` has no effect on the stored entry.
- R3: A wide write (`wr_fmt`=1) followed by a wide read (`rdN_fmt`=1) returns all 64 bits unchanged. This includes NaNs with non-canonical payloads. A wide read ignores `rdN_kind`.
- R4: A narrow transfer read (`rdN_fmt`=0, `rdN_kind`=0) returns `{32'h0, entry[31:0]}` whatever the high half holds, and keeps `rdN_nan_sub` at 0.
- R5: A narrow compute read (`rdN_fmt`=0, `rdN_kind`=1) of an entry whose bits 63:32 are all ones returns `{32'h0, entry[31:0]}` with `rdN_nan_sub`=0.
- R6: A narrow compute read of an entry with any zero among bits 63:32 returns `{32'h0, 32'h7FC0_0000}` with `rdN_nan_sub`=1.
- R7: After any narrow write, a wide read of that entry shows a negative quiet NaN: bit 63 is 1, bits 62:52 are all 1, and bit 51 is 1.
- R8: With `wr_en` low, no entry changes.
- R9: A write changes the entry at the rising edge. A read of the same address in the same cycle, before that edge, returns the old contents.
- R10: The two read ports are independent. Each port returns its own address, format and kind at the same time as the other.
- R11: `rdN_nan_sub` is 0 for every wide read and every transfer read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Write entry index |
| wr_data | input | 64 | Write data; only bits 31:0 used when narrow |
| wr_fmt | input | 1 | Write format: 0 = 32-bit, 1 = 64-bit |
| rd0_addr | input | 5 | Read port 0 entry index |
| rd0_fmt | input | 1 | Read port 0 format: 0 = 32-bit, 1 = 64-bit |
| rd0_kind | input | 1 | Read port 0 narrow kind: 0 = transfer, 1 = compute |
| rd0_data | output | 64 | Read port 0 data |
| rd0_nan_sub | output | 1 | Port 0 substituted canonical NaN |
| rd1_addr | input | 5 | Read port 1 entry index |
| rd1_fmt | input | 1 | Read port 1 format: 0 = 32-bit, 1 = 64-bit |
| rd1_kind | input | 1 | Read port 1 narrow kind: 0 = transfer, 1 = compute |
| rd1_data | output | 64 | Read port 1 data |
| rd1_nan_sub | output | 1 | Port 1 substituted canonical NaN |

## Verification
A faulty high half in an entry stays hidden from transfer reads. It shows up on the first wide read of that entry as a wrong upper word. On the first narrow compute read it shows as a spurious canonical NaN with the flag raised. Both appear combinationally in the cycle after the bad write. The sweep therefore reads every entry in all three modes on both ports right after each write. A lost or misdirected write shows on the next wide read of the target entry, and also as an unexpected change in a neighbouring entry. To expose a missing bit in the boxing test, the sweep clears each high bit on its own.

// File: rtl/fprf_pkg.sv
package fprf_pkg;

    localparam int FLEN      = 64;
    localparam int NLEN      = 32;
    localparam int NREG      = 32;
    localparam int AW        = $clog2(NREG);
    localparam int BOX_W     = FLEN - NLEN;

    localparam logic [NLEN-1:0]  CANON_NAN_S = 32'h7FC0_0000;
    localparam logic [BOX_W-1:0] BOX_ONES    = '1;

    typedef enum logic {
        FMT_S = 1'b0,
        FMT_D = 1'b1
    } fmt_e;

    typedef enum logic {
        RD_XFER = 1'b0,
        RD_COMP = 1'b1
    } rd_kind_e;

    typedef struct packed {
        logic            en;
        logic [AW-1:0]   addr;
        logic [FLEN-1:0] data;
        fmt_e            fmt;
    } wr_req_t;

    typedef struct packed {
        logic [AW-1:0] addr;
        fmt_e          fmt;
        rd_kind_e      kind;
    } rd_req_t;

    typedef struct packed {
        logic [FLEN-1:0] data;
        logic            nan_sub;
    } rd_rsp_t;

    function automatic logic [FLEN-1:0] box_narrow(input logic [NLEN-1:0] v);
        return {BOX_ONES, v};
    endfunction

    function automatic logic boxed_ok(input logic [FLEN-1:0] v);
        return &v[FLEN-1:NLEN];
    endfunction

    function automatic logic is_neg_qnan_d(input logic [FLEN-1:0] v);
        return v[63] && (&v[62:52]) && v[51];
    endfunction

endpackage

// File: rtl/fprf_boxer.sv
module fprf_boxer
    import fprf_pkg::*;
(
    input  wr_req_t         req,
    output logic [FLEN-1:0] word
);
    always_comb begin
        if (req.fmt == FMT_S) begin
            word = box_narrow(req.data[NLEN-1:0]);
        end else begin
            word = req.data;
        end
    end
endmodule

// File: rtl/fprf_entry.sv
module fprf_entry
    import fprf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [FLEN-1:0] d,
    output logic [FLEN-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (we) begin
            q <= d;
        end
    end
endmodule

// File: rtl/fprf_unboxer.sv
module fprf_unboxer
    import fprf_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  rd_req_t         req,
    input  logic [FLEN-1:0] raw,
    output rd_rsp_t         rsp
);
    always_comb begin
        rsp.nan_sub = 1'b0;
        if (req.fmt == FMT_D) begin
            rsp.data = raw;
        end else if (req.kind == RD_XFER) begin
            rsp.data = {{BOX_W{1'b0}}, raw[NLEN-1:0]};
        end else if (boxed_ok(raw)) begin
            rsp.data = {{BOX_W{1'b0}}, raw[NLEN-1:0]};
        end else begin
            rsp.data    = {{BOX_W{1'b0}}, CANON_NAN_S};
            rsp.nan_sub = 1'b1;
        end
    end

    AST_SUB_ONLY_NARROW_COMP: assert property (@(posedge clk) disable iff (rst)
        rsp.nan_sub |-> (req.fmt == FMT_S && req.kind == RD_COMP)); // R11
    AST_SUB_YIELDS_CANON: assert property (@(posedge clk) disable iff (rst)
        rsp.nan_sub |-> (rsp.data[NLEN-1:0] == CANON_NAN_S)); // R6
    AST_XFER_NEVER_SUB: assert property (@(posedge clk) disable iff (rst)
        (req.fmt == FMT_S && req.kind == RD_XFER) |-> (!rsp.nan_sub && rsp.data[NLEN-1:0] == raw[NLEN-1:0])); // R4
endmodule

// File: rtl/fprf_nanbox.sv
module fprf_nanbox
    import fprf_pkg::*;
#(
    parameter int NRD = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [4:0]  wr_addr,
    input  logic [63:0] wr_data,
    input  logic        wr_fmt,
    input  logic [4:0]  rd0_addr,
    input  logic        rd0_fmt,
    input  logic        rd0_kind,
    output logic [63:0] rd0_data,
    output logic        rd0_nan_sub,
    input  logic [4:0]  rd1_addr,
    input  logic        rd1_fmt,
    input  logic        rd1_kind,
    output logic [63:0] rd1_data,
    output logic        rd1_nan_sub
);
    wr_req_t                    wreq;
    logic [FLEN-1:0]            wword;
    logic [NREG-1:0][FLEN-1:0]  regs;
    rd_req_t                    rreq [NRD];
    rd_rsp_t                    rrsp [NRD];

    assign wreq.en   = wr_en;
    assign wreq.addr = wr_addr;
    assign wreq.data = wr_data;
    assign wreq.fmt  = fmt_e'(wr_fmt);

    fprf_boxer u_boxer (
        .req  (wreq),
        .word (wword)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_entry
        fprf_entry u_entry (
            .clk (clk),
            .rst (rst),
            .we  (wreq.en && (wreq.addr == AW'(i))),
            .d   (wword),
            .q   (regs[i])
        );
    end

    assign rreq[0] = '{addr: rd0_addr, fmt: fmt_e'(rd0_fmt), kind: rd_kind_e'(rd0_kind)};
    assign rreq[1] = '{addr: rd1_addr, fmt: fmt_e'(rd1_fmt), kind: rd_kind_e'(rd1_kind)};

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        fprf_unboxer u_unbox (
            .clk (clk),
            .rst (rst),
            .req (rreq[p]),
            .raw (regs[rreq[p].addr]),
            .rsp (rrsp[p])
        );
    end

    assign rd0_data    = rrsp[0].data;
    assign rd0_nan_sub = rrsp[0].nan_sub;
    assign rd1_data    = rrsp[1].data;
    assign rd1_nan_sub = rrsp[1].nan_sub;

    AST_RESET_CLEAR: assert property (@(posedge clk)
        $fell(rst) |-> (regs[0] == '0 && regs[NREG-1] == '0)); // R1
    AST_NARROW_WRITE_BOXED: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fmt == 1'b0) |=> (regs[$past(wr_addr)] == {BOX_ONES, $past(wr_data[NLEN-1:0])})); // R2
    AST_BOXED_IS_QNAN: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fmt == 1'b0) |=> is_neg_qnan_d(regs[$past(wr_addr)])); // R7
    AST_WIDE_WRITE_EXACT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_fmt == 1'b1) |=> (regs[$past(wr_addr)] == $past(wr_data))); // R3
    AST_HOLD_WITHOUT_WE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(regs)); // R8
endmodule

// File: tb/fprf_nanbox_test.sv
`timescale 1ns/1ps
module fprf_nanbox_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [63:0] wr_data = '0;
    logic        wr_fmt = 1'b0;
    logic [4:0]  rd0_addr = '0, rd1_addr = '0;
    logic        rd0_fmt = 1'b1, rd1_fmt = 1'b1;
    logic        rd0_kind = 1'b0, rd1_kind = 1'b0;
    logic [63:0] rd0_data, rd1_data;
    logic        rd0_nan_sub, rd1_nan_sub;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;
    logic [63:0] shadow [32];

    always #2.5 clk = ~clk;

    fprf_nanbox uut (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_fmt(wr_fmt),
        .rd0_addr(rd0_addr), .rd0_fmt(rd0_fmt), .rd0_kind(rd0_kind),
        .rd0_data(rd0_data), .rd0_nan_sub(rd0_nan_sub),
        .rd1_addr(rd1_addr), .rd1_fmt(rd1_fmt), .rd1_kind(rd1_kind),
        .rd1_data(rd1_data), .rd1_nan_sub(rd1_nan_sub)
    );

    task automatic chk(input string req, input logic [64:0] act, input logic [64:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Expected narrow compute result per R5/R6
    function automatic logic [64:0] exp_comp(input logic [63:0] e);
        if (&e[63:32]) return {32'h0, e[31:0], 1'b0};
        return {32'h0, 32'h7FC0_0000, 1'b1};
    endfunction

    task automatic do_write(input logic [4:0] a, input logic [63:0] d, input logic f);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; wr_fmt = f;
        @(negedge clk);
        wr_en = 1'b0;
        shadow[a] = f ? d : {32'hFFFF_FFFF, d[31:0]};
    endtask

    // Reads entry a on both ports in all modes, port 1 in a different mode than port 0 (R10)
    task automatic read_all(input logic [4:0] a, input string tag);
        logic [63:0] e;
        e = shadow[a];
        #1;
        rd0_addr = a; rd0_fmt = 1'b1; rd0_kind = 1'b1;          // wide, kind ignored (R3)
        rd1_addr = a; rd1_fmt = 1'b0; rd1_kind = 1'b0;          // narrow transfer (R4)
        #0.5;
        chk({tag, " R3 wide p0"}, {rd0_data, rd0_nan_sub}, {e, 1'b0});
        chk({tag, " R4 xfer p1"}, {rd1_data, rd1_nan_sub}, {32'h0, e[31:0], 1'b0});
        rd0_fmt = 1'b0; rd0_kind = 1'b1;                        // narrow compute (R5/R6)
        rd1_fmt = 1'b1; rd1_kind = 1'b0;
        #0.5;
        chk({tag, " R5_R6 comp p0"}, {rd0_data, rd0_nan_sub}, exp_comp(e));
        chk({tag, " R10_R11 wide p1"}, {rd1_data, rd1_nan_sub}, {e, 1'b0});
        rd0_fmt = 1'b0; rd0_kind = 1'b0;
        rd1_fmt = 1'b0; rd1_kind = 1'b1;
        #0.5;
        chk({tag, " R4_R11 xfer p0"}, {rd0_data, rd0_nan_sub}, {32'h0, e[31:0], 1'b0});
        chk({tag, " R5_R6 comp p1"}, {rd1_data, rd1_nan_sub}, exp_comp(e));
    endtask

    initial begin
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state of every entry
        for (int i = 0; i < 32; i++) read_all(5'(i), "R1");

        // R2/R7: narrow write to every entry, upper data bits junk
        for (int i = 0; i < 32; i++) begin
            logic [63:0] d;
            d = {32'h1234_0000 + 32'(i), 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0101)};
            do_write(5'(i), d, 1'b0);
            #1;
            rd0_addr = 5'(i); rd0_fmt = 1'b1;
            #0.5;
            chk("R2 narrow boxed", {1'b0, rd0_data}, {1'b0, 32'hFFFF_FFFF, d[31:0]});
            chk("R7 neg qNaN", {64'h0, rd0_data[63] & (&rd0_data[62:52]) & rd0_data[51]}, 65'h1);
            read_all(5'(i), "R2");
        end

        // R3: wide writes, including non-canonical NaN payloads
        for (int i = 0; i < 32; i++) begin
            logic [63:0] d;
            d = (i % 3 == 0) ? 64'h7FF0_0000_0000_0001 + 64'(i) :
                (i % 3 == 1) ? 64'hFFF4_DEAD_BEEF_0000 | 64'(i) :
                               64'h4009_21FB_5444_2D18 ^ {32'(i), 32'(i)};
            do_write(5'(i), d, 1'b1);
            read_all(5'(i), "R3");
        end

        // R6: clear each upper bit alone; compute read must substitute
        for (int b = 32; b < 64; b++) begin
            logic [63:0] d;
            d = 64'hFFFF_FFFF_3F80_0000;
            d[b] = 1'b0;
            do_write(5'(b - 32), d, 1'b1);
            read_all(5'(b - 32), "R6");
        end

        // R8: wr_en low leaves entries untouched
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 5'd7; wr_data = 64'h0123_4567_89AB_CDEF; wr_fmt = 1'b1;
        repeat (3) @(negedge clk);
        read_all(5'd7, "R8");

        // R9: same-cycle read returns old value; new value after edge
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 5'd9; wr_data = 64'hC000_0000_0000_0000; wr_fmt = 1'b1;
        rd0_addr = 5'd9; rd0_fmt = 1'b1;
        #1;
        chk("R9 no forward", {rd0_data, 1'b0}, {shadow[9], 1'b0});
        @(posedge clk); #1;
        chk("R9 after edge", {rd0_data, 1'b0}, {64'hC000_0000_0000_0000, 1'b0});
        @(negedge clk) wr_en = 1'b0;
        shadow[9] = 64'hC000_0000_0000_0000;
        read_all(5'd9, "R9");

        // R1: reset again clears entries
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int i = 0; i < 32; i++) shadow[i] = '0;
        read_all(5'd0, "R1b");
        read_all(5'd31, "R1b");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule